// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-up

This block receives asynchronous serial frames on a single line. A free-running tick at sixteen times the bit rate clocks it. It handles 7-bit and 8-bit characters with an optional parity bit, plus a 9-bit character format used on shared multidrop links. In the 9-bit format the extra bit marks a frame as an address or as data. With parity on and no queue, the parity bit received is kept in the same spare status bit. Each stored character carries its own parity-error and framing-error flags.

A node on a shared bus sets the wake-up enable. It then ignores every data frame and takes in, and interrupts on, only frames whose ninth bit is 1. Received characters sit in a single holding register. With the queue enable set, they go into a small queue of `DEPTH` entries instead. Software reads the head through the read port and pops it with a one-cycle read strobe. A frame that arrives while storage is full is dropped and raises a sticky overrun flag.

Top module: `uwr_top`

## Requirements
- R1: After synchronous reset, `rd_valid_o`, `irq_o` and `oerr_o` are 0, and a line held high captures nothing.
- R2: `mode_i`=1 selects 8 data bits, least significant first after the start bit. Without parity, `rd_bit9_o` and `rd_perr_o` read 0.
- R3: `mode_i`=0 selects 7 data bits. The stored byte has bit 7 cleared.
- R4: In 7/8-bit formats with `par_en_i`=1, one parity bit follows the data. `par_odd_i`=0 asks for an even count of ones over data plus parity, and 1 asks for an odd count. A mismatch sets `rd_perr_o` for that character. With the queue off, the received parity bit appears on `rd_bit9_o`.
- R5: `mode_i`=2 selects 8 data bits plus a ninth bit, stored on `rd_bit9_o`. Parity is not used in this format.
- R6: In `mode_i`=2 with `wake_en_i`=1, a frame whose ninth bit is 0 is discarded. It leaves the storage, the overrun flag and `irq_o` unchanged. A frame whose ninth bit is 1 is stored normally.
- R7: With `fifo_en_i`=1, up to `DEPTH` characters are kept in arrival order. The parity bit is not stored (`rd_bit9_o` reads 0), but `rd_perr_o` still reports the check.
- R8: With `fifo_en_i`=1 and `mode_i`=2, the receiver stays idle and captures no frame.
- R9: A start bit that stays low for less than half a bit time is rejected, and nothing is stored.
- R10: A stop bit whose majority vote reads low sets `rd_ferr_o` for that character, and the character is still stored.
- R11: A frame that completes while storage is full (1 entry with the queue off, `DEPTH` with it on) is dropped and sets `oerr_o`. The flag stays set until the next read strobe.
- R12: `irq_o` pulses high for exactly one cycle for each character stored, and at no other time.
- R13: A one-cycle `rd_i` pops the head character, if there is one, and clears `oerr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_i | input | 2 | Character format: 0 = 7-bit, 1 = 8-bit, 2 = 9-bit |
| par_en_i | input | 1 | Parity bit present in 7/8-bit formats |
| par_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| wake_en_i | input | 1 | Accept only frames with ninth bit 1 (9-bit format) |
| fifo_en_i | input | 1 | Use the DEPTH-entry queue instead of one register |
| rd_i | input | 1 | Pop head character and clear overrun |
| rd_data_o | output | 8 | Head character data |
| rd_bit9_o | output | 1 | Head ninth bit or parity bit |
| rd_perr_o | output | 1 | Head parity error |
| rd_ferr_o | output | 1 | Head framing error |
| rd_valid_o | output | 1 | At least one character stored |
| oerr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
A wrong bit counter or vote window shows up as a shifted or corrupted byte on `rd_data_o`. This is visible a few cycles after the stop bit's middle, well before the bench's next idle check. A broken wake-up gate or full test shows as an extra or missing `irq_o` pulse, or a change in `rd_valid_o`, within the same frame. A pointer fault in the queue only becomes visible when several entries are read back in order. Every stored character is compared against an independent queue on every clock outside the short window around each stop bit.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    typedef enum logic [1:0] {
        FMT_7  = 2'd0,
        FMT_8  = 2'd1,
        FMT_9  = 2'd2,
        FMT_8X = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic [3:0] data_bits(input fmt_e f);
        return (f == FMT_7) ? 4'd7 : 4'd8;
    endfunction

    function automatic logic has_extra(input fmt_e f, input logic par_en);
        return (f == FMT_9) || par_en;
    endfunction

endpackage

// File: rtl/uwr_bitrx.sv
module uwr_bitrx
    import uwr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick_i,
    input  fmt_e       fmt_i,
    input  logic       par_en_i,
    input  logic       hold_i,
    output logic [8:0] raw_o,
    output logic       done_o,
    output logic       stop_ok_o
);
    localparam int CW = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam logic [CW-1:0] V_FIRST = CW'(MID - 1);
    localparam logic [CW-1:0] V_LAST  = CW'(MID + 1);
    localparam logic [CW-1:0] S_DECIDE = CW'(MID + 2);
    localparam logic [CW-1:0] SLOT_END = CW'(OVS - 1);

    logic          s1, s2;
    rx_st_e        state;
    logic [CW-1:0] cnt;
    logic [2:0]    vote;
    logic [3:0]    idx;
    logic [3:0]    last_idx;
    logic          bit_val;

    assign last_idx = data_bits(fmt_i) + {3'd0, has_extra(fmt_i, par_en_i)} - 4'd1;
    assign bit_val  = maj3(vote);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= 1'b1;
            s2        <= 1'b1;
            state     <= RX_IDLE;
            cnt       <= '0;
            vote      <= '0;
            idx       <= '0;
            raw_o     <= '0;
            done_o    <= 1'b0;
            stop_ok_o <= 1'b1;
        end else begin
            s1     <= rx_i;
            s2     <= s1;
            done_o <= 1'b0;
            if (hold_i) begin
                state <= RX_IDLE;
            end else if (tick_i) begin
                if (state == RX_IDLE) begin
                    if (!s2) begin
                        state <= RX_START;
                        cnt   <= '0;
                        vote  <= '0;
                        raw_o <= '0;
                    end
                end else if (state == RX_STOP && cnt == S_DECIDE) begin
                    done_o    <= 1'b1;
                    stop_ok_o <= bit_val;
                    state     <= RX_IDLE;
                end else if (cnt == SLOT_END) begin
                    cnt <= '0;
                    if (state == RX_START) begin
                        if (bit_val) begin
                            state <= RX_IDLE;
                        end else begin
                            state <= RX_BITS;
                            idx   <= '0;
                        end
                    end else if (state == RX_BITS) begin
                        raw_o[idx] <= bit_val;
                        if (idx == last_idx) begin
                            state <= RX_STOP;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt >= V_FIRST && cnt <= V_LAST) begin
                        vote <= {vote[1:0], s2};
                    end
                end
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (state == RX_IDLE)); // R8
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(state) == RX_STOP)); // R10

endmodule

// File: rtl/uwr_decode.sv
module uwr_decode
    import uwr_pkg::*;
(
    input  logic [8:0] raw_i,
    input  logic       stop_ok_i,
    input  fmt_e       fmt_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       wake_en_i,
    input  logic       fifo_en_i,
    output rx_word_t   word_o,
    output logic       keep_o
);
    logic       is9;
    logic       par_used;
    logic       extra;
    logic [7:0] data;

    always_comb begin
        is9      = (fmt_i == FMT_9);
        par_used = par_en_i && !is9;
        extra    = (fmt_i == FMT_7) ? raw_i[7] : raw_i[8];
        data     = (fmt_i == FMT_7) ? {1'b0, raw_i[6:0]} : raw_i[7:0];

        word_o.data = data;
        if (is9) begin
            word_o.bit9 = extra;
        end else if (par_used && !fifo_en_i) begin
            word_o.bit9 = extra;
        end else begin
            word_o.bit9 = 1'b0;
        end
        word_o.perr = par_used && ((^data ^ extra) != par_odd_i);
        word_o.ferr = !stop_ok_i;
        keep_o      = !(is9 && wake_en_i && !extra);
    end

endmodule

// File: rtl/uwr_store.sv
module uwr_store
    import uwr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fifo_en_i,
    input  logic     push_i,
    input  rx_word_t word_i,
    input  logic     pop_i,
    output rx_word_t head_o,
    output logic     valid_o,
    output logic     stored_o,
    output logic     ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_word_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic [AW:0]   cap;
    logic          full;
    logic          do_push, do_pop;

    assign cap      = fifo_en_i ? (AW+1)'(DEPTH) : (AW+1)'(1);
    assign full     = (count >= cap);
    assign do_push  = push_i && !full;
    assign do_pop   = pop_i && (count != '0);
    assign stored_o = do_push;
    assign ovf_o    = push_i && full;
    assign valid_o  = (count != '0);
    assign head_o   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= word_i;
                wr_ptr      <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH)); // R11
    AST_QUEUE_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (push_i && fifo_en_i) |-> !word_i.bit9); // R7
    AST_SINGLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en_i && $past(!fifo_en_i) && $past(count) <= 1) |-> (count <= 1)); // R11

endmodule

// File: rtl/uwr_top.sv
module uwr_top
    import uwr_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [1:0] mode_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       wake_en_i,
    input  logic       fifo_en_i,
    input  logic       rd_i,
    output logic [7:0] rd_data_o,
    output logic       rd_bit9_o,
    output logic       rd_perr_o,
    output logic       rd_ferr_o,
    output logic       rd_valid_o,
    output logic       oerr_o,
    output logic       irq_o
);
    fmt_e     fmt;
    logic     hold;
    logic [8:0] raw;
    logic     done;
    logic     stop_ok;
    rx_word_t word;
    logic     keep;
    rx_word_t head;
    logic     stored;
    logic     ovf;

    assign fmt  = fmt_e'(mode_i);
    assign hold = (fmt == FMT_9) && fifo_en_i;

    uwr_bitrx #(.OVS(OVS)) u_bitrx (
        .clk       (clk),
        .rst       (rst),
        .rx_i      (rx_i),
        .tick_i    (tick_i),
        .fmt_i     (fmt),
        .par_en_i  (par_en_i),
        .hold_i    (hold),
        .raw_o     (raw),
        .done_o    (done),
        .stop_ok_o (stop_ok)
    );

    uwr_decode u_decode (
        .raw_i     (raw),
        .stop_ok_i (stop_ok),
        .fmt_i     (fmt),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .wake_en_i (wake_en_i),
        .fifo_en_i (fifo_en_i),
        .word_o    (word),
        .keep_o    (keep)
    );

    uwr_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .fifo_en_i (fifo_en_i),
        .push_i    (done && keep),
        .word_i    (word),
        .pop_i     (rd_i),
        .head_o    (head),
        .valid_o   (rd_valid_o),
        .stored_o  (stored),
        .ovf_o     (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o  <= 1'b0;
            oerr_o <= 1'b0;
        end else begin
            irq_o <= stored;
            if (ovf) begin
                oerr_o <= 1'b1;
            end else if (rd_i) begin
                oerr_o <= 1'b0;
            end
        end
    end

    assign rd_data_o = head.data;
    assign rd_bit9_o = head.bit9;
    assign rd_perr_o = head.perr;
    assign rd_ferr_o = head.ferr;

    AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> rd_valid_o); // R12
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R12
    AST_OERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (oerr_o && !rd_i) |=> oerr_o); // R11
    AST_OERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !ovf) |=> !oerr_o); // R13

endmodule

// File: tb/sim_uwr_top.sv
`timescale 1ns/1ps
module sim_uwr_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] mode = 2'd1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wake_en = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_perr, rd_ferr, rd_valid, oerr, irq;

    localparam int DEPTH = 4;

    uwr_top #(.OVS(16), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rx_i(rx), .tick_i(tick), .mode_i(mode),
        .par_en_i(par_en), .par_odd_i(par_odd), .wake_en_i(wake_en),
        .fifo_en_i(fifo_en), .rd_i(rd), .rd_data_o(rd_data), .rd_bit9_o(rd_bit9),
        .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_valid_o(rd_valid),
        .oerr_o(oerr), .irq_o(irq)
    );

    always #2 clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 3);
    end

    // reference model: {data[7:0], bit9, perr, ferr}
    logic [10:0] mq[$];
    logic  m_oerr = 1'b0;
    int    irq_exp = 0;
    int    irq_seen = 0;
    logic  guard = 1'b1;
    logic  irq_prev = 1'b0;
    string tag = "R1";
    int    total = 0;
    int    bad = 0;
    logic  finished = 1'b0;

    task automatic check(input string t, input logic ok, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic cmp(input string t);
        logic [10:0] h;
        check(t, rd_valid == (mq.size() > 0), "valid", int'(rd_valid), int'(mq.size() > 0));
        check(t, oerr == m_oerr, "oerr", int'(oerr), int'(m_oerr));
        if (mq.size() > 0) begin
            h = mq[0];
            check(t, {rd_data, rd_bit9, rd_perr, rd_ferr} == h, "head",
                  int'({rd_data, rd_bit9, rd_perr, rd_ferr}), int'(h));
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_seen++;
            if (!guard) cmp(tag);
            if (irq && irq_prev) check("R12", 1'b0, "irq width", 2, 1);
            irq_prev = irq;
        end
    end

    task automatic wt(input int n);
        repeat (n) begin
            @(posedge clk iff tick);
            #1;
        end
    endtask

    task automatic xfer(input logic [7:0] d, input logic x, input logic stop_v);
        int nd;
        logic hx;
        logic [7:0] dd;
        logic b9, pe;
        nd = (mode == 2'd0) ? 7 : 8;
        hx = (mode == 2'd2) || par_en;
        wt(1);
        rx = 1'b0;
        wt(16);
        for (int i = 0; i < nd; i++) begin
            rx = d[i];
            wt(16);
        end
        if (hx) begin
            rx = x;
            wt(16);
        end
        rx = stop_v;
        guard = 1'b1;
        wt(14);
        dd = (mode == 2'd0) ? {1'b0, d[6:0]} : d;
        b9 = (mode == 2'd2) ? x : ((par_en && !fifo_en) ? x : 1'b0);
        pe = par_en && (mode != 2'd2) && ((^dd ^ x) != par_odd);
        if (mode == 2'd2 && fifo_en) begin
        end else if (mode == 2'd2 && wake_en && !x) begin
        end else if (mq.size() >= (fifo_en ? DEPTH : 1)) begin
            m_oerr = 1'b1;
        end else begin
            mq.push_back({dd, b9, pe, !stop_v});
            irq_exp++;
        end
        guard = 1'b0;
        wt(2);
        rx = 1'b1;
        wt(20);
        check("R12", irq_seen == irq_exp, "irq count", irq_seen, irq_exp);
    endtask

    task automatic rd_pop;
        @(negedge clk);
        rd = 1'b1;
        @(posedge clk);
        #1;
        rd = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        m_oerr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1", !rd_valid && !irq && !oerr, "reset state",
              int'({rd_valid, irq, oerr}), 0);
        guard = 1'b0;
        tag = "R1";
        wt(40);
        cmp("R1");

        tag = "R2"; mode = 2'd1;
        xfer(8'hA5, 1'b0, 1'b1); cmp("R2"); rd_pop;
        xfer(8'h3C, 1'b0, 1'b1); cmp("R2"); rd_pop;

        tag = "R3"; mode = 2'd0;
        xfer(8'hFF, 1'b0, 1'b1); cmp("R3"); rd_pop;

        tag = "R4"; mode = 2'd1; par_en = 1'b1; par_odd = 1'b0;
        xfer(8'h31, 1'b1, 1'b1); cmp("R4"); rd_pop;
        xfer(8'h31, 1'b0, 1'b1); cmp("R4"); rd_pop;
        par_odd = 1'b1;
        xfer(8'h31, 1'b0, 1'b1); cmp("R4"); rd_pop;
        mode = 2'd0;
        xfer(8'h03, 1'b1, 1'b1); cmp("R4"); rd_pop;
        par_en = 1'b0; par_odd = 1'b0;

        tag = "R5"; mode = 2'd2;
        xfer(8'h55, 1'b1, 1'b1); cmp("R5"); rd_pop;
        xfer(8'h12, 1'b0, 1'b1); cmp("R5"); rd_pop;

        tag = "R6"; wake_en = 1'b1;
        xfer(8'h20, 1'b0, 1'b1); cmp("R6");
        xfer(8'h07, 1'b1, 1'b1); cmp("R6");
        xfer(8'h44, 1'b0, 1'b1); cmp("R6"); rd_pop;
        wake_en = 1'b0;

        tag = "R10"; mode = 2'd1;
        xfer(8'h9E, 1'b0, 1'b0); cmp("R10"); rd_pop;

        tag = "R9";
        wt(1); rx = 1'b0; wt(6); rx = 1'b1; wt(40);
        cmp("R9");
        check("R9", irq_seen == irq_exp, "irq count", irq_seen, irq_exp);

        tag = "R11";
        xfer(8'h11, 1'b0, 1'b1);
        xfer(8'h22, 1'b0, 1'b1); cmp("R11");
        wt(10); cmp("R11");
        tag = "R13";
        rd_pop; cmp("R13");

        tag = "R7"; fifo_en = 1'b1; par_en = 1'b1;
        xfer(8'h01, 1'b1, 1'b1);
        xfer(8'h02, 1'b0, 1'b1);
        xfer(8'h03, 1'b0, 1'b1);
        xfer(8'h80, 1'b1, 1'b1); cmp("R7");
        tag = "R11";
        xfer(8'h55, 1'b0, 1'b1); cmp("R11");
        tag = "R7";
        for (int i = 0; i < 4; i++) begin
            rd_pop; cmp("R7");
        end
        tag = "R13";
        rd_pop; cmp("R13");
        par_en = 1'b0;

        tag = "R8"; mode = 2'd2;
        xfer(8'h5A, 1'b1, 1'b1); cmp("R8");
        mode = 2'd1; fifo_en = 1'b0;
        xfer(8'hC3, 1'b0, 1'b1); cmp("R8"); rd_pop;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule